// File: doc/BRIEF.md
# Interleaved Per-Cycle Thread Selector

This block sits at the front of a single-issue pipelined core that runs several hardware thread contexts together, interleaving them one instruction at a time. It holds a separate program counter for each context. In every cycle it picks one thread in a fixed rotating order and sends that thread's PC to instruction fetch in the same cycle. It also sends the thread's index as a tag, which downstream stages carry alongside the instruction. No dead cycle is spent when the selected thread changes.

A thread can be chosen only if it is marked ready, its stall input is low, and it has no instruction still inside the pipeline. The last condition is tracked by a per-thread occupancy countdown that is as long as the pipeline. As a result, a thread never has two instructions in flight, and no hazard can occur within a thread. Later stages can overwrite the PC of any thread, for example with a branch target or a refill restart address. If no thread can be chosen, the block emits a bubble.

Top module: `fgmt_scheduler`

## Requirements
- R1: After a synchronous active-low reset, thread t's PC equals START_BASE + t*START_STRIDE, the rotation pointer selects thread 0, and no thread is counted as in flight.
- R2: The search for a thread starts at the rotation pointer and proceeds upward, wrapping from the highest index back to 0. After an issue, the pointer moves to one past the thread just issued, wrapping to 0.
- R3: A thread whose ready bit is 0 or whose stall bit is 1 is passed over in the same cycle, and the next eligible thread in rotation is issued instead.
- R4: The PC of the selected thread appears on fetch_pc_o combinationally in the cycle the thread is chosen, so a change of thread costs no cycle.
- R5: fetch_tid_o carries the binary index of the issued thread whenever fetch_valid_o is 1.
- R6: Each issue advances only the issued thread's PC, by INSTR_BYTES. All other PCs are unchanged.
- R7: When redirect_valid bit t is 1, thread t's PC takes the slice t*PC_W of redir_pc_i at the next edge. This holds even when thread t is issued in the same cycle.
- R8: After a thread issues, it cannot issue again for the next PIPE_STAGES-1 cycles, so it has at most one instruction among PIPE_STAGES stages.
- R9: When no thread is eligible, fetch_valid_o is 0, the rotation pointer holds, and no PC advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_ready_i | input | NUM_THREADS | Per-thread ready; 1 means the context is runnable |
| thr_stall_i | input | NUM_THREADS | Per-thread stall; 1 means skip this thread this cycle |
| redir_valid_i | input | NUM_THREADS | Per-thread PC overwrite request |
| redir_pc_i | input | NUM_THREADS*PC_W | Redirect targets, thread t in bits [t*PC_W +: PC_W] |
| fetch_valid_o | output | 1 | 1 when an instruction is issued this cycle |
| fetch_tid_o | output | $clog2(NUM_THREADS) | Thread tag of the issued instruction |
| fetch_pc_o | output | PC_W | Fetch address of the issued thread |

## Verification
A corrupted rotation pointer shows up in the first cycle after it goes wrong: the wrong thread tag appears while several threads are eligible. A stale occupancy count shows up as a tag that repeats too soon, or as an unexpected bubble within PIPE_STAGES cycles. A wrong per-thread PC stays hidden until that thread is next issued, which takes up to NUM_THREADS cycles or longer if it stalls. The stimulus therefore reissues every thread after each redirect, stall and bubble, so each stored PC is read back at the port.

// File: rtl/fgmt_pkg.sv
// Package: shared limits and the rotation helper for the thread selector.
// Assumes thread counts of 2..8 and integer-sized index arithmetic.
package fgmt_pkg;

    localparam int MAX_THREADS = 8;

    // Return idx+1 wrapped into 0..n-1.
    function automatic int rr_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    // Return base+off wrapped into 0..n-1 (off < n).
    function automatic int rr_add(input int base, input int off, input int n);
        return (base + off >= n) ? base + off - n : base + off;
    endfunction

endpackage

// File: rtl/fgmt_rr_pick.sv
// Rotating first-eligible picker. Starting at start_id, it scans the
// eligibility mask upward with wrap and returns the first set index.
// Assumes start_id < NUM_THREADS. Purely combinational.
module fgmt_rr_pick
    import fgmt_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS-1:0] elig_i,
    input  logic [TID_W-1:0]       start_id_i,
    output logic                   found_o,
    output logic [TID_W-1:0]       pick_o
);

    // Scan eligible threads in rotation order beginning at the pointer.
    always_comb begin
        int idx;
        found_o = 1'b0;
        pick_o  = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            idx = rr_add(int'(start_id_i), i, NUM_THREADS);
            if (!found_o && elig_i[idx]) begin
                found_o = 1'b1;
                pick_o  = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/fgmt_occupancy.sv
// Per-thread pipeline occupancy tracker. An issue loads a countdown of
// PIPE_STAGES-1, and a thread counts as free again only when its count
// reaches zero. Assumes PIPE_STAGES >= 2 and a one-hot issue vector.
module fgmt_occupancy #(
    parameter int NUM_THREADS = 4,
    parameter int PIPE_STAGES = 4,
    localparam int CNT_W = (PIPE_STAGES > 2) ? $clog2(PIPE_STAGES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] issue_oh_i,
    output logic [NUM_THREADS-1:0] free_o
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PIPE_STAGES - 1);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [CNT_W-1:0] cnt_q;

        // Load on issue, otherwise count down toward free.
        always_ff @(posedge clk) begin
            if (!rst_n)                cnt_q <= '0;
            else if (issue_oh_i[t])    cnt_q <= LOAD_VAL;
            else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
        end

        assign free_o[t] = (cnt_q == '0);

        // R8: a thread is never issued twice in consecutive cycles.
        a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
            issue_oh_i[t] |=> !issue_oh_i[t]);

        // R8: an issue may only hit a thread whose countdown has expired.
        a_r8_issue_when_free: assert property (@(posedge clk) disable iff (!rst_n)
            issue_oh_i[t] |-> (cnt_q == '0));
    end

endmodule

// File: rtl/fgmt_pc_bank.sv
// Bank of private program counters, one per thread context. Redirects
// take priority over the sequential advance. The read port is
// combinational so the chosen PC reaches fetch in the same cycle.
// Assumes a one-hot (or zero) issue vector.
module fgmt_pc_bank #(
    parameter int                NUM_THREADS  = 4,
    parameter int                PC_W         = 32,
    parameter int                INSTR_BYTES  = 4,
    parameter logic [PC_W-1:0]   START_BASE   = 32'h0000_1000,
    parameter logic [PC_W-1:0]   START_STRIDE = 32'h0000_0100,
    localparam int               TID_W        = $clog2(NUM_THREADS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THREADS-1:0]      issue_oh_i,
    input  logic [NUM_THREADS-1:0]      redir_v_i,
    input  logic [NUM_THREADS*PC_W-1:0] redir_pc_i,
    input  logic [TID_W-1:0]            rd_id_i,
    output logic [PC_W-1:0]             rd_pc_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] pc_q [NUM_THREADS];

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_pc
        localparam logic [PC_W-1:0] START_PC = START_BASE + PC_W'(t) * START_STRIDE;
        logic [PC_W-1:0] tgt;
        assign tgt = redir_pc_i[t*PC_W +: PC_W];

        // Hold, advance or overwrite this thread's PC.
        always_ff @(posedge clk) begin
            if (!rst_n)             pc_q[t] <= START_PC;
            else if (redir_v_i[t])  pc_q[t] <= tgt;
            else if (issue_oh_i[t]) pc_q[t] <= pc_q[t] + STEP;
        end

        // R7: a redirect lands regardless of a simultaneous issue.
        a_r7_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
            redir_v_i[t] |=> pc_q[t] == $past(tgt));

        // R6: an issue without a redirect steps the PC by one instruction.
        a_r6_step_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_oh_i[t] && !redir_v_i[t]) |=> pc_q[t] == $past(pc_q[t]) + STEP);

        // R6: no issue and no redirect leaves the PC untouched.
        a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!issue_oh_i[t] && !redir_v_i[t]) |=> $stable(pc_q[t]));
    end

    // Combinational read of the selected context's PC.
    assign rd_pc_o = pc_q[rd_id_i];

endmodule

// File: rtl/fgmt_scheduler.sv
// Fine-grained thread selector (top). Every cycle it chooses the next
// runnable thread in rotation, drives that thread's PC and tag to fetch
// with no switch penalty, and steps the rotation pointer past it.
// Assumes 2 <= NUM_THREADS <= 8, PIPE_STAGES >= 2, synchronous reset.
module fgmt_scheduler
    import fgmt_pkg::*;
#(
    parameter int              NUM_THREADS  = 4,
    parameter int              PIPE_STAGES  = 4,
    parameter int              PC_W         = 32,
    parameter int              INSTR_BYTES  = 4,
    parameter logic [PC_W-1:0] START_BASE   = 32'h0000_1000,
    parameter logic [PC_W-1:0] START_STRIDE = 32'h0000_0100,
    localparam int             TID_W        = $clog2(NUM_THREADS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THREADS-1:0]      thr_ready_i,
    input  logic [NUM_THREADS-1:0]      thr_stall_i,
    input  logic [NUM_THREADS-1:0]      redir_valid_i,
    input  logic [NUM_THREADS*PC_W-1:0] redir_pc_i,
    output logic                        fetch_valid_o,
    output logic [TID_W-1:0]            fetch_tid_o,
    output logic [PC_W-1:0]             fetch_pc_o
);

    logic [TID_W-1:0]       ptr_q;
    logic [NUM_THREADS-1:0] free_w;
    logic [NUM_THREADS-1:0] elig_w;
    logic [NUM_THREADS-1:0] issue_oh;
    logic                   found_w;
    logic [TID_W-1:0]       pick_w;

    // A thread is eligible when runnable, not stalled and out of the pipe.
    assign elig_w = thr_ready_i & ~thr_stall_i & free_w;

    fgmt_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
        .elig_i     (elig_w),
        .start_id_i (ptr_q),
        .found_o    (found_w),
        .pick_o     (pick_w)
    );

    // Expand the chosen index into a one-hot issue vector.
    always_comb begin
        issue_oh = '0;
        if (found_w) issue_oh[pick_w] = 1'b1;
    end

    fgmt_occupancy #(.NUM_THREADS(NUM_THREADS), .PIPE_STAGES(PIPE_STAGES)) u_occ (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_oh_i (issue_oh),
        .free_o     (free_w)
    );

    fgmt_pc_bank #(
        .NUM_THREADS (NUM_THREADS),
        .PC_W        (PC_W),
        .INSTR_BYTES (INSTR_BYTES),
        .START_BASE  (START_BASE),
        .START_STRIDE(START_STRIDE)
    ) u_pcs (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_oh_i (issue_oh),
        .redir_v_i  (redir_valid_i),
        .redir_pc_i (redir_pc_i),
        .rd_id_i    (pick_w),
        .rd_pc_o    (fetch_pc_o)
    );

    // Move the pointer one past the issued thread; hold it on a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (found_w) ptr_q <= TID_W'(rr_next(int'(pick_w), NUM_THREADS));
    end

    assign fetch_valid_o = found_w;
    assign fetch_tid_o   = pick_w;

    // R9: a bubble leaves the rotation pointer where it was.
    a_r9_bubble_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid_o |=> $stable(ptr_q));

    // R2: after an issue the pointer sits one past the issued thread.
    a_r2_ptr_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |=> int'(ptr_q) == rr_next(int'($past(fetch_tid_o)), NUM_THREADS));

    // R3: only a ready, unstalled thread is ever issued.
    a_r3_issue_runnable: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> (thr_ready_i[fetch_tid_o] && !thr_stall_i[fetch_tid_o]));

    // R5: at most one thread is issued per cycle.
    a_r5_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_oh));

endmodule

// File: tb/tb_fgmt_scheduler.sv
// Bench for fgmt_scheduler with 4 threads, a 4-stage pipe, base 0x1000
// and stride 0x100. A table of vectors is walked by one loop, then
// directed reset tests follow.
module tb_fgmt_scheduler;

    localparam int N  = 4;
    localparam int PW = 32;
    localparam int NV = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ready = '0;
    logic [N-1:0]    stall = '0;
    logic [N-1:0]    rv = '0;
    logic [N*PW-1:0] rpc = '0;
    logic            f_valid;
    logic [1:0]      f_tid;
    logic [PW-1:0]   f_pc;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    fgmt_scheduler #(.NUM_THREADS(N), .PIPE_STAGES(4), .PC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .thr_ready_i(ready), .thr_stall_i(stall),
        .redir_valid_i(rv), .redir_pc_i(rpc),
        .fetch_valid_o(f_valid), .fetch_tid_o(f_tid), .fetch_pc_o(f_pc)
    );

    // Stimulus and expected outputs, one row per cycle.
    localparam logic [3:0]  T_RDY [NV] = '{4'hF,4'hF,4'hF,4'hF,4'hF,4'hF,4'hD,4'hF,
                                          4'hF,4'hF,4'hF,4'hF,4'hF,4'h0,4'hF,4'hF};
    localparam logic [3:0]  T_STL [NV] = '{4'h0,4'h0,4'h0,4'h8,4'h0,4'h0,4'h0,4'h0,
                                          4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h2};
    localparam logic [3:0]  T_RV  [NV] = '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h8,
                                          4'h8,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0};
    localparam logic [31:0] T_RPC [NV] = '{32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,32'h0,
                                          32'h2000,32'h3000,32'h0,32'h0,32'h0,32'h0,
                                          32'h0,32'h0,32'h0};
    localparam logic        E_V   [NV] = '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,
                                          1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1};
    localparam logic [1:0]  E_TID [NV] = '{2'd0,2'd1,2'd2,2'd0,2'd3,2'd0,2'd2,2'd1,
                                          2'd3,2'd0,2'd2,2'd1,2'd3,2'd0,2'd0,2'd2};
    localparam logic [31:0] E_PC  [NV] = '{32'h1000,32'h1100,32'h1200,32'h0,32'h1300,
                                          32'h1004,32'h1204,32'h1104,32'h2000,32'h1008,
                                          32'h1208,32'h1108,32'h3000,32'h0,32'h100C,
                                          32'h120C};
    // Row notes: 0-2 R2/R4/R5 rotation; 3 R8+R3 bubble (all busy, T3
    // stalled) and R9; 4 R2 wrap; 5 R6 step; 6 R3 not-ready skip; 7 R7
    // redirect while idle; 8 R7 redirect during issue; 9-11 R8 occupancy
    // skips; 12 R7 redirect won; 13 R9 no ready; 14 R9 PC held; 15 R3 stall.

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sample(input string req, input logic ev, input logic [1:0] et,
                          input logic [31:0] ep);
        chk({req, " valid"}, 32'(f_valid), 32'(ev));
        if (ev) begin
            chk({req, " tid"}, 32'(f_tid), 32'(et));
            chk({req, " pc"}, f_pc, ep);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ready = '0; stall = '0; rv = '0; rpc = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state seen through the first issue, R4 same cycle.
        ready = 4'hF;
        #1 sample("R1 reset thread0", 1'b1, 2'd0, 32'h1000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int r = 0; r < NV; r++) begin
            ready = T_RDY[r]; stall = T_STL[r]; rv = T_RV[r];
            rpc = '0;
            for (int t = 0; t < N; t++) rpc[t*PW +: PW] = T_RPC[r];
            #1 sample($sformatf("row%0d R2-table", r), E_V[r], E_TID[r], E_PC[r]);
            @(negedge clk);
        end

        // R1: a mid-run reset restores start PCs and pointer at thread 0.
        do_reset();
        ready = 4'hF;
        #1 sample("R1 rerun t0", 1'b1, 2'd0, 32'h1000);
        @(negedge clk);
        #1 sample("R1 rerun t1", 1'b1, 2'd1, 32'h1100);
        @(negedge clk);
        // R8: only thread 3 ready but it is free; then T3 busy next -> bubble.
        ready = 4'h8;
        #1 sample("R8 t3 first", 1'b1, 2'd3, 32'h1300);
        @(negedge clk);
        #1 sample("R8 t3 busy", 1'b0, 2'd0, 32'h0);
        @(negedge clk);
        #1 sample("R8 t3 still busy", 1'b0, 2'd0, 32'h0);
        @(negedge clk);
        #1 sample("R8 t3 busy last", 1'b0, 2'd0, 32'h0);
        @(negedge clk);
        #1 sample("R8 t3 free again", 1'b1, 2'd3, 32'h1304);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule